// File: doc/BRIEF.md
# Sampling Converter Three-Wire Port Controller

This block is the device-side digital control of a 10-bit sampling converter that talks over a three-wire port: an active-falling convert strobe, a serial clock driven by the host, and a data output that is either driven or released. A falling strobe edge freezes the sample (hold), opens a frame and starts driving the data line low. The block then counts serial-clock rising edges. It shifts out a fixed sixteen-slot frame: three leading zeros, the ten result bits most significant first, two sub-bit slots, and a closing zero. On the fourteenth rising edge it releases the sampler back to tracking. The converted value comes in on a parallel port that stands in for the analog core. A parameter picks the unipolar variant, which sends straight binary, or the bipolar variant, which sends two's complement.

The edge at which the host raises the strobe again also selects the power mode. A return between the third and fourteenth rising edges asks for power-down. From the normal state this enters partial power-down. From partial power-down it enters full power-down. A frame that lasts at least fourteen rising edges before the strobe rises wakes the block back to normal. The first frame that completes after a hardware reset is a calibration frame whose data is marked invalid. Waking from power-down does not repeat it.

All three port lines are sampled in a single system clock domain, and their edges are detected there. The released state of the data line is modelled as an enable plus a data bit. Frame sequencer states: FR_IDLE (no frame open), FR_RUN (counting rising edges), FR_TAIL (frame finished with the strobe still low, waiting to release the line). Frame transitions: strobe fall from any state to FR_RUN; strobe rise from FR_RUN to FR_IDLE; the falling clock edge after the sixteenth rise, with the strobe low, from FR_RUN to FR_TAIL; a clock rise or strobe rise from FR_TAIL to FR_IDLE. Power states: PW_NORMAL, PW_PARTIAL, PW_FULL. Power transitions: a short return takes PW_NORMAL to PW_PARTIAL and PW_PARTIAL to PW_FULL. A long return takes PW_PARTIAL or PW_FULL to PW_NORMAL.

Top module: `adc_serial_port`

## Requirements
- R1: One system clock after a strobe falling edge is detected, `sdo_en_o` is 1, `sdo_o` is 0 and `hold_o` is 1, whatever state came before.
- R2: After the k-th serial-clock rising edge of a frame, `sdo_o` is 0 for k = 1..3, result bit 13-k for k = 4..13 (bit 9 first), and 0 for k = 14, 15 (sub-bit slots) and k = 16. Within a frame, `sdo_o` changes only on a clock rising edge or a frame start.
- R3: `hold_o` returns to 0 one system clock after the fourteenth serial-clock rising edge of a frame.
- R4: In PW_NORMAL, a strobe rise after 14 or more rising edges keeps `sdo_en_o` at 1, so a following frame can start back to back.
- R5: If the strobe is still low at the falling clock edge after the sixteenth rise, `sdo_en_o` drops to 0 on the next serial-clock rise or strobe rise, whichever is detected first.
- R6: A strobe rise after 3 to 13 rising edges moves `pwr_o` from 0 (normal) to 1 (partial), or from 1 to 2 (full), and drops `sdo_en_o`.
- R7: In partial or full power-down, a strobe rise after 14 or more rising edges returns `pwr_o` to 0 and drops `sdo_en_o`.
- R8: A strobe rise after fewer than 3 rising edges leaves `pwr_o` unchanged and drops `sdo_en_o`. In full power-down, a short return (3 to 13 edges) leaves `pwr_o` at 2.
- R9: `sample_ok_o` is set at each frame start. It is 0 for frames that begin before any frame has reached sixteen rising edges since reset, and 1 afterwards, including after leaving power-down.
- R10: With `BIPOLAR` = 0 the shifted result equals `sample_i`. With `BIPOLAR` = 1 the shifted result is `sample_i` with its top bit inverted (offset binary in, two's complement out).
- R11: During and right after reset, `sdo_en_o`, `sdo_o`, `hold_o`, `sample_ok_o` are 0 and `pwr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all port lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sclk_i | input | 1 | Serial clock from the host |
| conv_i | input | 1 | Convert strobe; a falling edge opens a frame |
| sample_i | input | DATA_W | Raw conversion result from the analog core, latched at frame start |
| sdo_o | output | 1 | Serial data bit |
| sdo_en_o | output | 1 | Data line driven when 1, released when 0 |
| hold_o | output | 1 | 1 while the sampler holds, 0 while it tracks |
| pwr_o | output | 2 | Power state: 0 normal, 1 partial, 2 full |
| sample_ok_o | output | 1 | 1 when the current frame carries a valid sample |

## Verification
A wrong edge count shifts every data slot. The error shows on `sdo_o` at the fourth rising edge of the first frame, where bit 9 would land one slot early or late. The same wrong count also moves `hold_o` off the fourteenth edge. A wrong power state shows at the next strobe rise: `pwr_o` takes the wrong code, or `sdo_en_o` stays high when it should release, within one system clock. A lost calibration flag shows as a wrong `sample_ok_o` at the very next frame start, which is why the bench repeats a reset late in the run.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        PW_NORMAL  = 2'd0,
        PW_PARTIAL = 2'd1,
        PW_FULL    = 2'd2
    } pwr_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RUN  = 2'd1,
        FR_TAIL = 2'd2
    } frame_t;

endpackage

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
    parameter int DATA_W  = 10,
    parameter bit BIPOLAR = 1'b0
) (
    input  logic [DATA_W-1:0] raw_i,
    output logic [DATA_W-1:0] code_o
);

    generate
        if (BIPOLAR) begin : g_twos
            // offset binary to two's complement: flip the sign position
            assign code_o = {~raw_i[DATA_W-1], raw_i[DATA_W-2:0]};
        end else begin : g_straight
            assign code_o = raw_i;
        end
    endgenerate

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
    import adc_port_pkg::*;
#(
    parameter int CW    = 5,
    parameter int PD_LO = 3,
    parameter int PD_HI = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_up_i,
    input  logic [CW-1:0] cnt_i,
    output pwr_t          pwr_o
);

    localparam logic [CW-1:0] C_LO = CW'(PD_LO);
    localparam logic [CW-1:0] C_HI = CW'(PD_HI);

    pwr_t pwr_q, pwr_n;
    logic short_ret, long_ret;

    assign short_ret = strobe_up_i && (cnt_i >= C_LO) && (cnt_i < C_HI);
    assign long_ret  = strobe_up_i && (cnt_i >= C_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= PW_NORMAL;
        else        pwr_q <= pwr_n;
    end

    always_comb begin
        pwr_n = pwr_q;
        unique case (pwr_q)
            PW_NORMAL:  if (short_ret) pwr_n = PW_PARTIAL;
            PW_PARTIAL: begin
                if (short_ret)     pwr_n = PW_FULL;
                else if (long_ret) pwr_n = PW_NORMAL;
            end
            PW_FULL:    if (long_ret) pwr_n = PW_NORMAL;
            default:    pwr_n = PW_NORMAL;
        endcase
    end

    assign pwr_o = pwr_q;

    // R6: full power-down is only reachable through partial
    p_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q == PW_NORMAL) |=> (pwr_q != PW_FULL));

    // R8: the power state moves only on a strobe return inside a frame
    p_pwr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_up_i |=> $stable(pwr_q));

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_port_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LEAD   = 3,
    parameter int SUBS   = 2,
    parameter int CW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              conv_rise_i,
    input  logic              conv_fall_i,
    input  logic              conv_lvl_i,
    input  logic [DATA_W-1:0] code_i,
    input  pwr_t              pwr_i,
    output logic              in_frame_o,
    output logic [CW-1:0]     cnt_o,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              hold_o,
    output logic              ok_o
);

    localparam int FRAME_LEN = LEAD + DATA_W + SUBS + 1;
    localparam int TRACK_AT  = LEAD + DATA_W + 1;
    localparam logic [CW-1:0] C_LEAD  = CW'(LEAD);
    localparam logic [CW-1:0] C_LAST  = CW'(LEAD + DATA_W);
    localparam logic [CW-1:0] C_TRACK = CW'(TRACK_AT);
    localparam logic [CW-1:0] C_FRAME = CW'(FRAME_LEN);

    frame_t st_q, st_n;
    logic [CW-1:0]     cnt_q, cnt_nx;
    logic [DATA_W-1:0] sr_q;
    logic sdo_q, en_q, hold_q, ok_q, cal_q;
    logic is_data, keep_drive;

    assign cnt_nx     = cnt_q + 1'b1;
    assign is_data    = (cnt_nx > C_LEAD) && (cnt_nx <= C_LAST);
    assign keep_drive = (pwr_i == PW_NORMAL) && (cnt_q >= C_TRACK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        if (conv_fall_i) begin
            st_n = FR_RUN;
        end else begin
            unique case (st_q)
                FR_IDLE: st_n = FR_IDLE;
                FR_RUN: begin
                    if (conv_rise_i)
                        st_n = FR_IDLE;
                    else if (sclk_fall_i && (cnt_q == C_FRAME) && !conv_lvl_i)
                        st_n = FR_TAIL;
                end
                FR_TAIL: if (conv_rise_i || sclk_rise_i) st_n = FR_IDLE;
                default: st_n = FR_IDLE;
            endcase
        end
    end

    // frame outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sr_q   <= '0;
            sdo_q  <= 1'b0;
            en_q   <= 1'b0;
            hold_q <= 1'b0;
            ok_q   <= 1'b0;
            cal_q  <= 1'b0;
        end else if (conv_fall_i) begin
            cnt_q  <= '0;
            sr_q   <= code_i;
            sdo_q  <= 1'b0;
            en_q   <= 1'b1;
            hold_q <= 1'b1;
            ok_q   <= cal_q;
        end else if (st_q == FR_RUN && conv_rise_i) begin
            hold_q <= 1'b0;
            if (!keep_drive) en_q <= 1'b0;
        end else if (st_q == FR_RUN && sclk_rise_i && cnt_q < C_FRAME) begin
            cnt_q <= cnt_nx;
            if (is_data) begin
                sdo_q <= sr_q[DATA_W-1];
                sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
            end else begin
                sdo_q <= 1'b0;
            end
            if (cnt_nx == C_TRACK) hold_q <= 1'b0;
            if (cnt_nx == C_FRAME) cal_q  <= 1'b1;
        end else if (st_q == FR_TAIL && (sclk_rise_i || conv_rise_i)) begin
            en_q <= 1'b0;
        end
    end

    assign in_frame_o = (st_q != FR_IDLE);
    assign cnt_o      = cnt_q;
    assign sdo_o      = sdo_q;
    assign sdo_en_o   = en_q;
    assign hold_o     = hold_q;
    assign ok_o       = ok_q;

    // R1: a frame start drives the line low and holds the sample
    p_start_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_fall_i |=> (en_q && !sdo_q && hold_q));

    // R2: the data bit moves only on a clock rise or a frame start
    p_sdo_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise_i && !conv_fall_i) |=> $stable(sdo_q));

    // R3: tracking resumes at the fourteenth rise
    p_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_RUN && sclk_rise_i && !conv_fall_i && !conv_rise_i
         && cnt_q == C_TRACK - 1'b1) |=> !hold_q);

    // R5: a finished frame with the strobe low releases the line
    p_tail_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_TAIL && (sclk_rise_i || conv_rise_i) && !conv_fall_i) |=> !en_q);

    // R9: once calibrated, the flag stays set until reset
    p_cal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_q |=> cal_q);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int LEAD    = 3,
    parameter int SUBS    = 2,
    parameter bit BIPOLAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              conv_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              hold_o,
    output logic [1:0]        pwr_o,
    output logic              sample_ok_o
);

    localparam int FRAME_LEN = LEAD + DATA_W + SUBS + 1;
    localparam int CW        = $clog2(FRAME_LEN + 1);
    localparam int TRACK_AT  = LEAD + DATA_W + 1;

    logic sclk_q, conv_q;
    logic sclk_rise, sclk_fall, conv_rise, conv_fall;
    logic [DATA_W-1:0] code;
    logic in_frame;
    logic [CW-1:0] cnt;
    pwr_t pwr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            conv_q <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            conv_q <= conv_i;
        end
    end

    assign sclk_rise = sclk_i && !sclk_q;
    assign sclk_fall = !sclk_i && sclk_q;
    assign conv_rise = conv_i && !conv_q;
    assign conv_fall = !conv_i && conv_q;

    adc_code_fmt #(.DATA_W(DATA_W), .BIPOLAR(BIPOLAR)) u_fmt (
        .raw_i  (sample_i),
        .code_o (code)
    );

    adc_frame_seq #(.DATA_W(DATA_W), .LEAD(LEAD), .SUBS(SUBS), .CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .conv_rise_i (conv_rise),
        .conv_fall_i (conv_fall),
        .conv_lvl_i  (conv_i),
        .code_i      (code),
        .pwr_i       (pwr),
        .in_frame_o  (in_frame),
        .cnt_o       (cnt),
        .sdo_o       (sdo_o),
        .sdo_en_o    (sdo_en_o),
        .hold_o      (hold_o),
        .ok_o        (sample_ok_o)
    );

    adc_pwr_fsm #(.CW(CW), .PD_LO(LEAD), .PD_HI(TRACK_AT)) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_up_i (conv_rise && in_frame),
        .cnt_i       (cnt),
        .pwr_o       (pwr)
    );

    assign pwr_o = pwr;

    // R7: waking from power-down never leaves the line driven
    p_wake_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr != PW_NORMAL && conv_rise && in_frame) |=> !sdo_en_o);

endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;

    localparam int CLK_P = 10;

    localparam logic [6:0] M_OK   = 7'b0000001;
    localparam logic [6:0] M_PWR  = 7'b0000110;
    localparam logic [6:0] M_HOLD = 7'b0001000;
    localparam logic [6:0] M_SDO  = 7'b0010000;
    localparam logic [6:0] M_EN   = 7'b0100000;
    localparam logic [6:0] M_BI   = 7'b1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic conv = 1'b1;
    logic [9:0] sample = '0;

    logic sdo, sdo_en, hold, ok;
    logic [1:0] pwr;
    logic bi_sdo, bi_en, bi_hold, bi_ok;
    logic [1:0] bi_pwr;

    int n_chk = 0;
    int n_fail = 0;
    int bcnt = 0;
    logic [9:0] cur = '0;
    bit done = 1'b0;

    logic [6:0] q_exp[$];
    logic [6:0] q_msk[$];
    string      q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    adc_serial_port #(.BIPOLAR(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .conv_i(conv), .sample_i(sample),
        .sdo_o(sdo), .sdo_en_o(sdo_en), .hold_o(hold), .pwr_o(pwr), .sample_ok_o(ok)
    );

    adc_serial_port #(.BIPOLAR(1'b1)) uut_bi (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .conv_i(conv), .sample_i(sample),
        .sdo_o(bi_sdo), .sdo_en_o(bi_en), .hold_o(bi_hold), .pwr_o(bi_pwr), .sample_ok_o(bi_ok)
    );

    // scoreboard monitor: compare queued expectations with the ports
    initial begin
        logic [6:0] e, m, obs;
        string t;
        forever begin
            wait (q_exp.size() != 0);
            e = q_exp.pop_front();
            m = q_msk.pop_front();
            t = q_tag.pop_front();
            obs = {bi_sdo, sdo_en, sdo, hold, pwr, ok};
            n_chk++;
            if ((obs & m) !== (e & m)) begin
                n_fail++;
                $display("FAIL %s: actual=%b expected=%b (mask %b)", t, obs & m, e & m, m);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic push(input string tag, input logic [6:0] e, input logic [6:0] m);
        q_exp.push_back(e);
        q_msk.push_back(m);
        q_tag.push_back(tag);
    endtask

    function automatic logic slot(input int n, input logic [9:0] v);
        if (n >= 4 && n <= 13) return v[13-n];
        return 1'b0;
    endfunction

    task automatic begin_frame(input logic [9:0] smp, input logic ok_e);
        sample = smp;
        cur = smp;
        bcnt = 0;
        conv = 1'b0;
        @(negedge clk);
        push("R1 frame start", 7'b0101000, M_EN | M_SDO | M_HOLD);
        push("R9 sample-valid flag at frame start", {6'b0, ok_e}, M_OK);
    endtask

    task automatic edges(input int n);
        logic eb, bb;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            @(negedge clk);
            bcnt++;
            eb = slot(bcnt, cur);
            bb = slot(bcnt, {~cur[9], cur[8:0]});
            push("R2 slot after rise", {1'b0, 1'b1, eb, 4'b0}, M_EN | M_SDO);
            push("R10 two's complement slot", {bb, 6'b0}, M_BI);
            if (bcnt == 14) push("R3 track at fourteenth rise", 7'b0, M_HOLD);
            sclk = 1'b0;
            @(negedge clk);
            push("R2 no change on fall", {1'b0, 1'b1, eb, 4'b0}, M_EN | M_SDO);
        end
    endtask

    task automatic end_frame();
        conv = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push("R11 state in reset", 7'b0, 7'b1111111);
        rst_n = 1'b1;
        @(negedge clk);
        push("R11 state after reset", 7'b0, 7'b1111111);

        // calibration frame, released by a clock rise after the tail
        begin_frame(10'h2D5, 1'b0);
        edges(16);
        sclk = 1'b1;
        @(negedge clk);
        push("R5 release on clock rise after tail", 7'b0, M_EN);
        sclk = 1'b0;
        @(negedge clk);
        end_frame();
        push("R5 line stays released", 7'b0, M_EN | M_PWR);

        // back-to-back frames
        begin_frame(10'h13A, 1'b1);
        edges(14);
        end_frame();
        push("R4 continuous return keeps drive", 7'b0100000, M_EN | M_PWR);
        begin_frame(10'h200, 1'b1);
        edges(16);
        end_frame();
        push("R5 release on strobe rise after tail", 7'b0, M_EN | M_PWR);

        // power-down sequence
        begin_frame(10'h0F0, 1'b1);
        edges(5);
        end_frame();
        push("R6 enter partial", 7'b0000010, M_EN | M_PWR);
        begin_frame(10'h155, 1'b1);
        edges(8);
        end_frame();
        push("R6 partial to full", 7'b0000100, M_EN | M_PWR);
        begin_frame(10'h0AA, 1'b1);
        edges(3);
        end_frame();
        push("R8 short return keeps full", 7'b0000100, M_EN | M_PWR);
        begin_frame(10'h3C3, 1'b1);
        edges(14);
        end_frame();
        push("R7 wake from full", 7'b0, M_EN | M_PWR);

        // abort before the power window
        begin_frame(10'h001, 1'b1);
        edges(2);
        end_frame();
        push("R8 early return leaves power state", 7'b0, M_EN | M_PWR);

        // partial at the window edge, then wake with a full frame
        begin_frame(10'h111, 1'b1);
        edges(13);
        end_frame();
        push("R6 thirteenth-edge return enters partial", 7'b0000010, M_EN | M_PWR);
        begin_frame(10'h222, 1'b1);
        edges(16);
        end_frame();
        push("R7 wake from partial after tail", 7'b0, M_EN | M_PWR);

        // second hardware reset restores calibration need
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R11 state after second reset", 7'b0, 7'b1111111);
        begin_frame(10'h2AA, 1'b0);
        edges(16);
        end_frame();
        begin_frame(10'h3FF, 1'b1);
        edges(16);
        end_frame();

        wait (q_exp.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule